// File: doc/BRIEF.md
# Reference Divider and Phase Comparator with Power-Save Resync

This block sits in the digital part of a frequency synthesizer loop. It divides the oscillator clock by a programmable 14-bit ratio to make a reference pulse train. It compares that train against the pulse train that comes back from the feedback divider. The result drives an external charge pump as a three-state output: drive high, drive low or high impedance. The block also keeps a lock indication.

To save power, the loop can be run in bursts. While the power-save input is low, the counters stop, the charge-pump drive goes to high impedance and the lock output holds its locked level. When the input goes high again, the reference counter reloads. In the same cycle the block sends a one-cycle restart strobe to the feedback divider, so both dividers start their periods together. The comparator therefore resumes with almost no phase error, rather than producing one large correction burst.

Top module: `refpfd_resync`

## Requirements
- R1: While rst_ni is low and up to the first cycle with ps_i high, fr_o, fb_restart_o, do_up_o, do_dn_o and do_oe_o are 0 and ld_o is 1.
- R2: In active mode fr_o is a one-clock pulse that repeats every R clocks, where R is the value on r_div_i.
- R3: A value on r_div_i below 5 acts as a ratio of 5.
- R4: A new r_div_i value is used from the next terminal count on. The period in progress ends with the ratio it started with.
- R5: ps_i is sampled on clk_i. Once ps_i has been low for two clocks, fr_o, do_up_o, do_dn_o and do_oe_o stay 0 and ld_o stays 1 for as long as it stays low.
- R6: On the first clock edge with ps_i high after a low level, the reference counter restarts and fb_restart_o goes high for exactly one cycle. The next fr_o pulse comes R clocks after the cycle in which the strobe is visible.
- R7: do_up_o is set by an fr pulse and do_dn_o by an fp pulse. Once both pulses have arrived, both are cleared together, so coincident pulses drive neither. The two are never high together, and do_oe_o equals do_up_o OR do_dn_o.
- R8: If the reference runs faster than fp, only do_up_o pulses. If fp runs faster, only do_dn_o pulses.
- R9: ld_o rises after LOCK_CNT consecutive reference periods in which no drive pulse lasts more than LOCK_WIN clocks. While locked, ld_o falls on the clock after a drive has been high for LOCK_WIN+1 consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ps_i | input | 1 | 1 = active, 0 = power save |
| r_div_i | input | R_W | Reference division ratio |
| fp_i | input | 1 | One-clock pulse from the feedback divider |
| fr_o | output | 1 | Reference pulse |
| fb_restart_o | output | 1 | One-cycle restart strobe for the feedback divider |
| do_up_o | output | 1 | Charge pump drive-high enable |
| do_dn_o | output | 1 | Charge pump drive-low enable |
| do_oe_o | output | 1 | Charge pump output enable (0 = high impedance) |
| ld_o | output | 1 | Lock detect |

## Verification
The hardest situation to reach from the ports is the behaviour of the comparator just after leaving power save. It only means something if the feedback side really restarts on the strobe. The bench therefore contains a small feedback divider of its own. That divider is reloaded by fb_restart_o and is given matched and mismatched ratios in turn, and each vector passes through a power-save interval first. The lock drop is reached by locking the loop and then changing the feedback ratio mid-run, counting the consecutive drive cycles at the ports.

// File: rtl/refpfd_pkg.sv
package refpfd_pkg;
  localparam int unsigned DEF_R_W      = 14;
  localparam int unsigned DEF_R_MIN    = 5;
  localparam int unsigned DEF_LOCK_CNT = 4;
  localparam int unsigned DEF_LOCK_WIN = 2;

  typedef struct packed {
    logic up;
    logic dn;
  } drive_t;
endpackage

// File: rtl/refpfd_ref_div.sv
module refpfd_ref_div #(
  parameter int unsigned R_W   = refpfd_pkg::DEF_R_W,
  parameter int unsigned R_MIN = refpfd_pkg::DEF_R_MIN
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           restart_i,
  input  logic [R_W-1:0] r_div_i,
  output logic           fr_o
);
  logic [R_W-1:0] cnt_q, r_q, r_eff;
  logic           fr_q, term;

  assign r_eff = (r_div_i < R_W'(R_MIN)) ? R_W'(R_MIN) : r_div_i;
  assign term  = (cnt_q == r_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      r_q   <= R_W'(R_MIN);
      fr_q  <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '0;
      r_q   <= r_eff;
      fr_q  <= 1'b0;
    end else if (run_i) begin
      if (term) begin
        cnt_q <= '0;
        r_q   <= r_eff;   // new ratio only at terminal count
        fr_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        fr_q  <= 1'b0;
      end
    end else begin
      fr_q <= 1'b0;
    end
  end

  assign fr_o = fr_q;

  assert_fr_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_q |=> !fr_q);
  assert_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0) && !fr_q);
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !restart_i) |=> $stable(cnt_q) && !fr_q);
endmodule

// File: rtl/refpfd_pfd.sv
module refpfd_pfd (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               fr_i,
  input  logic               fp_i,
  output refpfd_pkg::drive_t drv_o
);
  refpfd_pkg::drive_t drv_q, drv_n;

  always_comb begin
    drv_n.up = drv_q.up | fr_i;
    drv_n.dn = drv_q.dn | fp_i;
    if (!en_i || (drv_n.up && drv_n.dn)) drv_n = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drv_q <= '0;
    else         drv_q <= drv_n;
  end

  assign drv_o = drv_q;

  assert_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drv_q.up && drv_q.dn));
  assert_coinc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fr_i && fp_i) |=> !drv_q.up && !drv_q.dn);
  assert_park_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !drv_q.up && !drv_q.dn);
endmodule

// File: rtl/refpfd_lock.sv
module refpfd_lock #(
  parameter int unsigned LOCK_CNT = refpfd_pkg::DEF_LOCK_CNT,
  parameter int unsigned LOCK_WIN = refpfd_pkg::DEF_LOCK_WIN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic fr_i,
  input  logic err_i,
  output logic ld_o
);
  localparam int unsigned W_W = $clog2(LOCK_WIN + 2);
  localparam int unsigned G_W = $clog2(LOCK_CNT + 1);

  logic [W_W-1:0] w_q;
  logic [G_W-1:0] good_q;
  logic           bad_q, ld_q, big;

  assign big = err_i && (w_q >= W_W'(LOCK_WIN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q    <= '0;
      good_q <= '0;
      bad_q  <= 1'b0;
      ld_q   <= 1'b0;
    end else if (en_i) begin
      if (!err_i)                         w_q <= '0;
      else if (w_q < W_W'(LOCK_WIN))      w_q <= w_q + 1'b1;
      if (big) begin
        ld_q   <= 1'b0;
        good_q <= '0;
        bad_q  <= 1'b1;
      end else if (fr_i) begin
        if (bad_q) begin
          bad_q  <= 1'b0;
          good_q <= '0;
        end else if (good_q >= G_W'(LOCK_CNT - 1)) begin
          ld_q <= 1'b1;
        end else begin
          good_q <= good_q + 1'b1;
        end
      end
    end
  end

  assign ld_o = ld_q;

  assert_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && big) |=> !ld_q);
  assert_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ld_q) |-> $past(fr_i) && $past(en_i));
  assert_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(ld_q));
endmodule

// File: rtl/refpfd_resync.sv
module refpfd_resync #(
  parameter int unsigned R_W      = refpfd_pkg::DEF_R_W,
  parameter int unsigned R_MIN    = refpfd_pkg::DEF_R_MIN,
  parameter int unsigned LOCK_CNT = refpfd_pkg::DEF_LOCK_CNT,
  parameter int unsigned LOCK_WIN = refpfd_pkg::DEF_LOCK_WIN
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ps_i,
  input  logic [R_W-1:0] r_div_i,
  input  logic           fp_i,
  output logic           fr_o,
  output logic           fb_restart_o,
  output logic           do_up_o,
  output logic           do_dn_o,
  output logic           do_oe_o,
  output logic           ld_o
);
  logic               ps_q, restart_q, rise, fr, ld_int;
  refpfd_pkg::drive_t drv;

  assign rise = ps_i & ~ps_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q      <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      ps_q      <= ps_i;
      restart_q <= rise;
    end
  end

  refpfd_ref_div #(.R_W(R_W), .R_MIN(R_MIN)) u_ref (
    .clk_i, .rst_ni,
    .run_i     (ps_q),
    .restart_i (rise),
    .r_div_i,
    .fr_o      (fr)
  );

  refpfd_pfd u_pfd (
    .clk_i, .rst_ni,
    .en_i  (ps_q),
    .fr_i  (fr),
    .fp_i,
    .drv_o (drv)
  );

  refpfd_lock #(.LOCK_CNT(LOCK_CNT), .LOCK_WIN(LOCK_WIN)) u_lock (
    .clk_i, .rst_ni,
    .en_i  (ps_q),
    .fr_i  (fr),
    .err_i (drv.up | drv.dn),
    .ld_o  (ld_int)
  );

  assign fr_o         = fr;
  assign fb_restart_o = restart_q;
  assign do_up_o      = drv.up;
  assign do_dn_o      = drv.dn;
  assign do_oe_o      = ps_q & (drv.up | drv.dn);
  assign ld_o         = ps_q ? ld_int : 1'b1;

  assert_restart_once_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_restart_o |=> !fb_restart_o);
  assert_restart_active_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_restart_o |-> ps_q && !fr_o);
endmodule

// File: tb/refpfd_resync_test.sv
`timescale 1ns/1ps
module refpfd_resync_test;
  localparam int R_W = 14, LOCK_CNT = 4, LOCK_WIN = 2, NV = 7;
  // {r, n, expected period, dir (0 none, 1 up only, 2 down only), expected ld}
  localparam logic [44:0] VEC [NV] = '{
    {14'd10,  14'd10,  14'd10,  2'd0, 1'b1},
    {14'd8,   14'd12,  14'd8,   2'd1, 1'b0},
    {14'd12,  14'd7,   14'd12,  2'd2, 1'b0},
    {14'd2,   14'd5,   14'd5,   2'd0, 1'b1},
    {14'd5,   14'd5,   14'd5,   2'd0, 1'b1},
    {14'd0,   14'd5,   14'd5,   2'd0, 1'b1},
    {14'd300, 14'd300, 14'd300, 2'd0, 1'b1}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst_ni, ps_i, fp_i;
  logic [R_W-1:0] r_div_i;
  logic           fr_o, fb_restart_o, do_up_o, do_dn_o, do_oe_o, ld_o;
  int nchk = 0, nfail = 0, fcnt = 0, n_div = 10;

  refpfd_resync #(.R_W(R_W), .LOCK_CNT(LOCK_CNT), .LOCK_WIN(LOCK_WIN)) uut (
    .clk_i(clk), .rst_ni, .ps_i, .r_div_i, .fp_i,
    .fr_o, .fb_restart_o, .do_up_o, .do_dn_o, .do_oe_o, .ld_o
  );

  // feedback divider model, restarted by the strobe
  initial fp_i = 1'b0;
  always @(negedge clk) begin
    if (fb_restart_o === 1'b1) begin
      fcnt = 0; fp_i = 1'b0;
    end else begin
      fcnt++;
      if (fcnt >= n_div) begin fp_i = 1'b1; fcnt = 0; end
      else fp_i = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic enter_save();
    int bad = 0;
    @(negedge clk) ps_i = 1'b0;
    repeat (2) @(negedge clk);
    repeat (4) begin
      @(negedge clk);
      if (do_oe_o || !ld_o || fr_o || do_up_o || do_dn_o) bad++;
    end
    chk(bad == 0, "R5 save outputs parked", bad, 0);
  endtask

  task automatic resume(input int r, input int n);
    @(posedge clk) n_div = n;
    @(negedge clk) begin r_div_i = R_W'(r); ps_i = 1'b1; end
    @(negedge clk);
    chk(fb_restart_o == 1'b1, "R6 strobe on resume", fb_restart_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; ps_i = 1'b0; r_div_i = 14'd10;
    repeat (3) @(negedge clk);
    chk({fr_o, fb_restart_o, do_up_o, do_dn_o, do_oe_o, ld_o} == 6'b000001,
        "R1 reset state", {fr_o, fb_restart_o, do_up_o, do_dn_o, do_oe_o, ld_o}, 1);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk({fr_o, fb_restart_o, do_oe_o, ld_o} == 4'b0001, "R1 idle after reset",
        {fr_o, fb_restart_o, do_oe_o, ld_o}, 1);

    for (int v = 0; v < NV; v++) begin
      int vr, vn, vp, vd, vl, first, gap_err, last, saw_up, saw_dn, oe_err;
      vr = int'(VEC[v][44:31]); vn = int'(VEC[v][30:17]);
      vp = int'(VEC[v][16:3]);  vd = int'(VEC[v][2:1]); vl = int'(VEC[v][0]);
      enter_save();
      resume(vr, vn);
      first = -1; last = 0; gap_err = 0; saw_up = 0; saw_dn = 0; oe_err = 0;
      for (int i = 1; i <= 6 * vp; i++) begin
        @(negedge clk);
        if (i == 1) chk(fb_restart_o == 1'b0, "R6 strobe one cycle", fb_restart_o, 0);
        if (fr_o) begin
          if (first < 0) first = i;
          else if (i - last != vp) gap_err++;
          last = i;
        end
        if (do_up_o) saw_up = 1;
        if (do_dn_o) saw_dn = 1;
        if ((do_oe_o != (do_up_o | do_dn_o)) || (do_up_o && do_dn_o)) oe_err++;
      end
      chk(first == vp, "R6 first fr after resync", first, vp);
      if (vr < 5) chk(gap_err == 0, "R3 clamped period", gap_err, 0);
      else        chk(gap_err == 0, "R2 fr period", gap_err, 0);
      chk(oe_err == 0, "R7 drive encoding", oe_err, 0);
      if (vd == 0)      chk(!saw_up && !saw_dn, "R7 in phase no drive", saw_up*2+saw_dn, 0);
      else if (vd == 1) chk(saw_up && !saw_dn, "R8 up only", saw_up*2+saw_dn, 2);
      else              chk(!saw_up && saw_dn, "R8 down only", saw_up*2+saw_dn, 1);
      chk(ld_o == vl[0], "R9 lock level", ld_o, vl);
    end

    // R4: ratio change mid-period
    begin
      int t1, t2;
      enter_save();
      resume(10, 10);
      t1 = -1; t2 = -1;
      for (int i = 1; i <= 40; i++) begin
        @(negedge clk);
        if (i == 3) r_div_i = 14'd7;
        if (fr_o) begin
          if (t1 < 0) t1 = i;
          else if (t2 < 0) t2 = i;
        end
      end
      chk(t1 == 10, "R4 period in progress keeps old ratio", t1, 10);
      chk(t2 == 17, "R4 new ratio after terminal count", t2, 17);
    end

    // R9: immediate drop on long error
    begin
      int run, done;
      enter_save();
      resume(10, 10);
      repeat (80) @(negedge clk);
      chk(ld_o == 1'b1, "R9 locked before disturbance", ld_o, 1);
      @(posedge clk) n_div = 20;
      run = 0; done = 0;
      for (int i = 0; i < 200 && !done; i++) begin
        @(negedge clk);
        run = do_up_o ? run + 1 : 0;
        if (run == LOCK_WIN + 1) chk(ld_o == 1'b1, "R9 window tolerated", ld_o, 1);
        if (run == LOCK_WIN + 2) begin
          chk(ld_o == 1'b0, "R9 drop after window", ld_o, 0);
          done = 1;
        end
      end
      chk(done == 1, "R9 long error reached", done, 1);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule